// File: doc/BRIEF.md
# Fully Associative Translation Cache with Access Permissions

This block keeps a small set of recent page translations in front of a page table walker. A lookup presents a virtual address and an access type. In the same cycle the block reports one of three results: a permitted translation, giving the physical address; a protection fault; or a miss. The page offset is carried through to the physical address without change. Every entry holds a valid flag, a read/write/execute permission triple, a virtual page tag and a physical page number. Any entry can hold any tag.

After a miss, the walker reads the page table in memory and installs the result through the fill port. The block never changes a stored entry on its own. Permission or status changes reach it only through a fill or an invalidate, so its contents always come from the page table. Maintenance can drop one translation, matched by tag, or all translations at once.

When a fill installs a new tag, it takes the lowest-numbered empty entry. When no entry is empty, a round-robin pointer chooses the entry to evict. A fill whose tag is already present rewrites that entry in place.

Top module: `tlb_fa`

## Requirements
- R1: After reset no entry is valid: every lookup reports neither hit nor fault, and `lk_paddr` is zero.
- R2: A lookup whose tag matches a valid entry whose permissions allow the access raises `lk_hit` in the same cycle, with `lk_paddr` = {stored physical page, offset bits of `lk_vaddr`}.
- R3: Access codes on `lk_acc` are 00 read, 01 write, 10 execute and 11 reserved. Permission bits are `fill_perm[0]` read, `[1]` write and `[2]` execute. A match whose access is not permitted, or any match with code 11, raises `lk_fault`, keeps `lk_hit` low and drives `lk_paddr` to zero.
- R4: With no matching valid entry, or with `lk_req` low, `lk_hit` and `lk_fault` are both low and `lk_paddr` is zero.
- R5: A fill sampled at a rising edge is visible to lookups from the next cycle on.
- R6: A fill whose tag is already valid in some entry rewrites that entry, so at most one entry ever matches a tag.
- R7: A fill with a new tag uses the lowest-index invalid entry. If all entries are valid, it evicts the entry at a round-robin pointer. The pointer is 0 after reset and advances by one, wrapping, only on such an eviction.
- R8: A single invalidate (`inv_en` high, `inv_all` low) clears only the entry whose tag equals `inv_vpn`. Other entries are unaffected.
- R9: An invalidate with `inv_all` high clears every entry in one cycle.
- R10: When `inv_en` and `fill_en` are high in the same cycle, the invalidate is performed and the fill is dropped.
- R11: Lookups, including faulting ones, never change any entry or the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | VPN_W+OFFS_W | Virtual address to translate |
| lk_acc | input | 2 | Access type code |
| lk_hit | output | 1 | Permitted translation found |
| lk_fault | output | 1 | Match found but access not permitted |
| lk_paddr | output | PPN_W+OFFS_W | Physical address, zero unless hit |
| fill_en | input | 1 | Install a translation |
| fill_vpn | input | VPN_W | Tag to install |
| fill_ppn | input | PPN_W | Physical page to install |
| fill_perm | input | 3 | Execute, write, read permission bits |
| inv_en | input | 1 | Invalidate request |
| inv_all | input | 1 | Invalidate every entry instead of one |
| inv_vpn | input | VPN_W | Tag to invalidate |

## Verification
Lookup results have no register between input and output: they are due in the cycle the inputs are applied. The bench therefore samples one time unit after driving the inputs at a falling edge, before the next rising edge arrives. Fills and invalidates take effect at the first rising edge that samples them. Each is held for exactly one clock, from one falling edge to the next, and its effect is checked through lookups in the cycle that follows. The replacement order is observed only through which earlier tags stop hitting, counted fill by fill from reset.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  localparam int PERM_R = 0;
  localparam int PERM_W = 1;
  localparam int PERM_X = 2;

  // Decide whether a stored permission triple admits an access code.
  function automatic logic perm_allows(input logic [2:0] perm, input logic [1:0] acc);
    logic ok;
    case (acc)
      ACC_READ:  ok = perm[PERM_R];
      ACC_WRITE: ok = perm[PERM_W];
      ACC_EXEC:  ok = perm[PERM_X];
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction

  // Next value of a wrapping round-robin index.
  function automatic int unsigned rr_next(input int unsigned cur, input int unsigned limit);
    return (cur + 1 >= limit) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int NUM   = 128,
  parameter int VPN_W = 20,
  parameter int PPN_W = 18
) (
  input  logic [NUM-1:0]            ent_vld,
  input  logic [NUM-1:0][VPN_W-1:0] ent_tag,
  input  logic [NUM-1:0][PPN_W-1:0] ent_ppn,
  input  logic [NUM-1:0][2:0]       ent_perm,
  input  logic [VPN_W-1:0]          key,
  output logic [NUM-1:0]            match_vec,
  output logic                      any_match,
  output logic [$clog2(NUM)-1:0]    match_idx,
  output logic [PPN_W-1:0]          sel_ppn,
  output logic [2:0]                sel_perm
);
  localparam int IDX_W = $clog2(NUM);

  for (genvar g = 0; g < NUM; g++) begin : g_cmp
    assign match_vec[g] = ent_vld[g] && (ent_tag[g] == key);
  end

  assign any_match = |match_vec;

  // At most one entry matches, so an OR of masked fields selects it.
  always_comb begin
    sel_ppn   = '0;
    sel_perm  = '0;
    match_idx = '0;
    for (int i = 0; i < NUM; i++) begin
      if (match_vec[i]) begin
        sel_ppn   = sel_ppn | ent_ppn[i];
        sel_perm  = sel_perm | ent_perm[i];
        match_idx = match_idx | IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int NUM = 128
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM-1:0]         ent_vld,
  input  logic                   evict_take,
  output logic [$clog2(NUM)-1:0] victim_idx,
  output logic                   all_full,
  output logic [$clog2(NUM)-1:0] rr_ptr
);
  import tlb_pkg::*;
  localparam int IDX_W = $clog2(NUM);

  logic [IDX_W-1:0] free_idx;

  assign all_full = &ent_vld;

  // Lowest-index empty slot: scan downward so the last write wins.
  always_comb begin
    free_idx = '0;
    for (int i = NUM - 1; i >= 0; i--) begin
      if (!ent_vld[i]) free_idx = IDX_W'(i);
    end
  end

  assign victim_idx = all_full ? rr_ptr : free_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rr_ptr <= '0;
    else if (evict_take) rr_ptr <= IDX_W'(rr_next(int'(rr_ptr), NUM));
  end
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa #(
  parameter int NUM_ENTRIES = 128,
  parameter int VPN_W       = 20,
  parameter int PPN_W       = 18,
  parameter int OFFS_W      = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    lk_req,
  input  logic [VPN_W+OFFS_W-1:0] lk_vaddr,
  input  logic [1:0]              lk_acc,
  output logic                    lk_hit,
  output logic                    lk_fault,
  output logic [PPN_W+OFFS_W-1:0] lk_paddr,
  input  logic                    fill_en,
  input  logic [VPN_W-1:0]        fill_vpn,
  input  logic [PPN_W-1:0]        fill_ppn,
  input  logic [2:0]              fill_perm,
  input  logic                    inv_en,
  input  logic                    inv_all,
  input  logic [VPN_W-1:0]        inv_vpn
);
  import tlb_pkg::*;
  localparam int IDX_W = $clog2(NUM_ENTRIES);
  localparam int VA_W  = VPN_W + OFFS_W;

  // Entry storage
  logic [NUM_ENTRIES-1:0]            ent_vld;
  logic [NUM_ENTRIES-1:0][VPN_W-1:0] ent_tag;
  logic [NUM_ENTRIES-1:0][PPN_W-1:0] ent_ppn;
  logic [NUM_ENTRIES-1:0][2:0]       ent_perm;

  // Lookup side
  logic [VPN_W-1:0]       lk_vpn;
  logic [OFFS_W-1:0]      lk_off;
  logic [NUM_ENTRIES-1:0] lk_match_vec;
  logic                   lk_any;
  logic [IDX_W-1:0]       lk_idx_unused;
  logic [PPN_W-1:0]       lk_ppn;
  logic [2:0]             lk_perm;
  logic                   lk_ok;

  assign lk_vpn = lk_vaddr[VA_W-1:OFFS_W];
  assign lk_off = lk_vaddr[OFFS_W-1:0];

  tlb_match #(.NUM(NUM_ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_lk_match (
    .ent_vld   (ent_vld),
    .ent_tag   (ent_tag),
    .ent_ppn   (ent_ppn),
    .ent_perm  (ent_perm),
    .key       (lk_vpn),
    .match_vec (lk_match_vec),
    .any_match (lk_any),
    .match_idx (lk_idx_unused),
    .sel_ppn   (lk_ppn),
    .sel_perm  (lk_perm)
  );

  assign lk_ok    = perm_allows(lk_perm, lk_acc);
  assign lk_hit   = lk_req && lk_any && lk_ok;
  assign lk_fault = lk_req && lk_any && !lk_ok;
  assign lk_paddr = lk_hit ? {lk_ppn, lk_off} : '0;

  // Maintenance side: invalidate wins over fill
  logic                   fill_do;
  logic                   inv_one;
  logic                   inv_every;
  logic [VPN_W-1:0]       mt_key;
  logic [NUM_ENTRIES-1:0] mt_match_vec;
  logic                   mt_any;
  logic [IDX_W-1:0]       mt_idx;
  logic [PPN_W-1:0]       mt_ppn_unused;
  logic [2:0]             mt_perm_unused;
  logic [IDX_W-1:0]       victim_idx;
  logic                   all_full;
  logic [IDX_W-1:0]       rr_ptr;
  logic                   evict;
  logic [IDX_W-1:0]       wr_idx;

  assign fill_do   = fill_en && !inv_en;
  assign inv_one   = inv_en && !inv_all;
  assign inv_every = inv_en && inv_all;
  assign mt_key    = inv_en ? inv_vpn : fill_vpn;

  tlb_match #(.NUM(NUM_ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_mt_match (
    .ent_vld   (ent_vld),
    .ent_tag   (ent_tag),
    .ent_ppn   (ent_ppn),
    .ent_perm  (ent_perm),
    .key       (mt_key),
    .match_vec (mt_match_vec),
    .any_match (mt_any),
    .match_idx (mt_idx),
    .sel_ppn   (mt_ppn_unused),
    .sel_perm  (mt_perm_unused)
  );

  assign evict  = fill_do && !mt_any && all_full;
  assign wr_idx = mt_any ? mt_idx : victim_idx;

  tlb_victim #(.NUM(NUM_ENTRIES)) u_victim (
    .clk        (clk),
    .rst_n      (rst_n),
    .ent_vld    (ent_vld),
    .evict_take (evict),
    .victim_idx (victim_idx),
    .all_full   (all_full),
    .rr_ptr     (rr_ptr)
  );

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    logic wr_here;
    assign wr_here = fill_do && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_vld[g] <= 1'b0;
      end else if (inv_every || (inv_one && mt_match_vec[g])) begin
        ent_vld[g] <= 1'b0;
      end else if (wr_here) begin
        ent_vld[g] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_here) begin
        ent_tag[g]  <= fill_vpn;
        ent_ppn[g]  <= fill_ppn;
        ent_perm[g] <= fill_perm;
      end
    end
  end
endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk #(
  parameter int NUM_ENTRIES = 128,
  parameter int VPN_W       = 20,
  parameter int PPN_W       = 18,
  parameter int OFFS_W      = 12
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          lk_req,
  input logic [VPN_W+OFFS_W-1:0]       lk_vaddr,
  input logic                          lk_hit,
  input logic                          lk_fault,
  input logic [PPN_W+OFFS_W-1:0]       lk_paddr,
  input logic                          fill_en,
  input logic [VPN_W-1:0]              fill_vpn,
  input logic                          inv_en,
  input logic                          inv_all,
  input logic [NUM_ENTRIES-1:0]        lk_match_vec,
  input logic                          evict,
  input logic [$clog2(NUM_ENTRIES)-1:0] rr_ptr
);
  localparam int VA_W = VPN_W + OFFS_W;

  AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match_vec)) else $error("duplicate tag match"); // R6

  AST_HIT_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_fault)) else $error("hit and fault together"); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |-> (!lk_hit && !lk_fault)) else $error("result without request"); // R4

  AST_NO_HIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_paddr == '0)) else $error("address without hit"); // R4

  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_paddr[OFFS_W-1:0] == lk_vaddr[OFFS_W-1:0])) else $error("offset altered"); // R2

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_en && inv_all) |=> (!lk_hit && !lk_fault)) else $error("entry survived flush"); // R9

  AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !inv_en) |=>
      (!(lk_req && (lk_vaddr[VA_W-1:OFFS_W] == $past(fill_vpn))) || lk_hit || lk_fault))
    else $error("filled tag not found"); // R5

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !evict |=> $stable(rr_ptr)) else $error("pointer moved without eviction"); // R7
endmodule

bind tlb_fa tlb_fa_chk #(
  .NUM_ENTRIES(NUM_ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .OFFS_W(OFFS_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .lk_req       (lk_req),
  .lk_vaddr     (lk_vaddr),
  .lk_hit       (lk_hit),
  .lk_fault     (lk_fault),
  .lk_paddr     (lk_paddr),
  .fill_en      (fill_en),
  .fill_vpn     (fill_vpn),
  .inv_en       (inv_en),
  .inv_all      (inv_all),
  .lk_match_vec (lk_match_vec),
  .evict        (evict),
  .rr_ptr       (rr_ptr)
);

// File: tb/tb_tlb_fa.sv
`timescale 1ns/1ps
module tb_tlb_fa;
  localparam int N     = 128;
  localparam int VPN_W = 20;
  localparam int PPN_W = 18;
  localparam int OFFS_W = 12;
  localparam logic [OFFS_W-1:0] OFF = 12'hABC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_req = 1'b0;
  logic [VPN_W+OFFS_W-1:0] lk_vaddr = '0;
  logic [1:0] lk_acc = '0;
  logic lk_hit, lk_fault;
  logic [PPN_W+OFFS_W-1:0] lk_paddr;
  logic fill_en = 1'b0;
  logic [VPN_W-1:0] fill_vpn = '0;
  logic [PPN_W-1:0] fill_ppn = '0;
  logic [2:0] fill_perm = '0;
  logic inv_en = 1'b0, inv_all = 1'b0;
  logic [VPN_W-1:0] inv_vpn = '0;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  tlb_fa #(.NUM_ENTRIES(N), .VPN_W(VPN_W), .PPN_W(PPN_W), .OFFS_W(OFFS_W)) dut (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vaddr(lk_vaddr), .lk_acc(lk_acc),
    .lk_hit(lk_hit), .lk_fault(lk_fault), .lk_paddr(lk_paddr),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_perm(fill_perm),
    .inv_en(inv_en), .inv_all(inv_all), .inv_vpn(inv_vpn)
  );

  // Vector: vpn(20) acc(2) hit(1) fault(1) ppn(18)
  localparam int NV = 12;
  localparam logic [41:0] VEC [NV] = '{
    {20'h00010, 2'b00, 1'b1, 1'b0, 18'h00100},
    {20'h00010, 2'b01, 1'b0, 1'b1, 18'h0},
    {20'h00010, 2'b10, 1'b0, 1'b1, 18'h0},
    {20'h00020, 2'b01, 1'b1, 1'b0, 18'h00200},
    {20'h00020, 2'b10, 1'b0, 1'b1, 18'h0},
    {20'h00030, 2'b10, 1'b1, 1'b0, 18'h00300},
    {20'h00030, 2'b00, 1'b0, 1'b1, 18'h0},
    {20'h00040, 2'b00, 1'b1, 1'b0, 18'h00400},
    {20'h00040, 2'b01, 1'b1, 1'b0, 18'h00400},
    {20'h00040, 2'b11, 1'b0, 1'b1, 18'h0},
    {20'h00050, 2'b00, 1'b0, 1'b1, 18'h0},
    {20'h00060, 2'b00, 1'b0, 1'b0, 18'h0}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Combinational lookup: drive after a falling edge, sample 1 ns later.
  task automatic expect_look(input string req, input logic [VPN_W-1:0] vpn, input logic [1:0] acc,
                             input logic eh, input logic ef, input logic [PPN_W-1:0] eppn);
    logic [PPN_W+OFFS_W-1:0] epa;
    @(negedge clk);
    lk_req = 1'b1; lk_vaddr = {vpn, OFF}; lk_acc = acc;
    #1;
    epa = eh ? {eppn, OFF} : '0;
    check({req, " hit"}, 64'(lk_hit), 64'(eh));
    check({req, " fault"}, 64'(lk_fault), 64'(ef));
    check({req, " paddr"}, 64'(lk_paddr), 64'(epa));
    lk_req = 1'b0;
  endtask

  task automatic do_fill(input logic [VPN_W-1:0] v, input logic [PPN_W-1:0] p, input logic [2:0] pm);
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = v; fill_ppn = p; fill_perm = pm;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic do_inv(input logic all, input logic [VPN_W-1:0] v);
    @(negedge clk);
    inv_en = 1'b1; inv_all = all; inv_vpn = v;
    @(negedge clk);
    inv_en = 1'b0; inv_all = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: empty after reset
    expect_look("R1 reset read", 20'h00010, 2'b00, 1'b0, 1'b0, 18'h0);
    expect_look("R1 reset exec", 20'h00000, 2'b10, 1'b0, 1'b0, 18'h0);

    // Setup fills; R5 visible the cycle after
    do_fill(20'h00010, 18'h00100, 3'b001);
    do_fill(20'h00020, 18'h00200, 3'b011);
    do_fill(20'h00030, 18'h00300, 3'b100);
    do_fill(20'h00040, 18'h00400, 3'b111);
    do_fill(20'h00050, 18'h00500, 3'b000);

    // R2 R3 R4 table walk
    for (int i = 0; i < NV; i++) begin
      expect_look($sformatf("R2/R3 vec%0d", i), VEC[i][41:22], VEC[i][21:20],
                  VEC[i][19], VEC[i][18], VEC[i][17:0]);
    end

    // R4: request low on a permitted tag
    @(negedge clk);
    lk_req = 1'b0; lk_vaddr = {20'h00040, OFF}; lk_acc = 2'b00;
    #1;
    check("R4 idle hit", 64'(lk_hit), 64'd0);
    check("R4 idle paddr", 64'(lk_paddr), 64'd0);

    // R11: repeated faulting lookups leave entry usable
    expect_look("R11 fault a", 20'h00010, 2'b01, 1'b0, 1'b1, 18'h0);
    expect_look("R11 fault b", 20'h00010, 2'b01, 1'b0, 1'b1, 18'h0);
    expect_look("R11 after", 20'h00010, 2'b00, 1'b1, 1'b0, 18'h00100);

    // R6: overwrite in place
    do_fill(20'h00010, 18'h01234, 3'b010);
    expect_look("R6 new write", 20'h00010, 2'b01, 1'b1, 1'b0, 18'h01234);
    expect_look("R6 old read", 20'h00010, 2'b00, 1'b0, 1'b1, 18'h0);

    // R8: single invalidate
    do_inv(1'b0, 20'h00020);
    expect_look("R8 gone", 20'h00020, 2'b01, 1'b0, 1'b0, 18'h0);
    expect_look("R8 other", 20'h00030, 2'b10, 1'b1, 1'b0, 18'h00300);

    // R10: fill and invalidate together
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = 20'h00070; fill_ppn = 18'h00700; fill_perm = 3'b111;
    inv_en = 1'b1; inv_all = 1'b0; inv_vpn = 20'h00030;
    @(negedge clk);
    fill_en = 1'b0; inv_en = 1'b0;
    expect_look("R10 fill dropped", 20'h00070, 2'b00, 1'b0, 1'b0, 18'h0);
    expect_look("R10 inv done", 20'h00030, 2'b10, 1'b0, 1'b0, 18'h0);

    // R9: flush
    do_inv(1'b1, 20'h0);
    expect_look("R9 flush a", 20'h00040, 2'b00, 1'b0, 1'b0, 18'h0);
    expect_look("R9 flush b", 20'h00010, 2'b01, 1'b0, 1'b0, 18'h0);

    // R7: fill every slot, then evict via pointer (still 0)
    for (int i = 0; i < N; i++) do_fill(20'h01000 + 20'(i), 18'h10000 + 18'(i), 3'b001);
    expect_look("R7 full last", 20'h01000 + 20'(N-1), 2'b00, 1'b1, 1'b0, 18'h10000 + 18'(N-1));
    do_fill(20'h02000, 18'h02000, 3'b001);
    expect_look("R7 evict0", 20'h01000, 2'b00, 1'b0, 1'b0, 18'h0);
    expect_look("R7 keep1", 20'h01001, 2'b00, 1'b1, 1'b0, 18'h10001);
    expect_look("R7 new", 20'h02000, 2'b00, 1'b1, 1'b0, 18'h02000);
    do_fill(20'h02001, 18'h02001, 3'b001);
    expect_look("R7 evict1", 20'h01001, 2'b00, 1'b0, 1'b0, 18'h0);
    // R7: an invalid slot is preferred over the pointer (now 2)
    do_inv(1'b0, 20'h01005);
    do_fill(20'h03000, 18'h03000, 3'b001);
    expect_look("R7 free pref", 20'h01002, 2'b00, 1'b1, 1'b0, 18'h10002);
    expect_look("R7 free used", 20'h03000, 2'b00, 1'b1, 1'b0, 18'h03000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule